// File: doc/BRIEF.md
# Bank-Group Read Command Scheduler

This block chooses which pending DRAM read goes onto the command bus on each controller clock. Reads enter an internal eight-entry queue, each tagged with a 2-bit bank-group number and a 2-bit bank number inside that group. The scheduler holds one countdown timer per bank group and one per bank. A queued read is a candidate only when both timers that cover it have reached zero.

Among the candidates, the scheduler favours the oldest read whose group differs from the group of the previous read. This makes consecutive reads alternate between groups, so the data bus keeps streaming the multi-beat prefetch bursts. If every candidate targets the previous group, the oldest candidate goes anyway. Issuing a read removes it from the queue in the same clock.

Two spacing values are supplied as inputs. One is the minimum distance between reads to the same group. The other is the minimum distance between any two reads to different banks. Configuration expects the same-group value to be at least the different-bank value, and both to be at least 2.

Top module: `bg_read_sched`

## Requirements
- R1: At most one read is issued per clock. The issued group and bank are those of a read that was accepted and has not yet been issued.
- R2: Two reads to the same bank group are never issued on adjacent clocks.
- R3: After a read to group g issues in cycle c, no other read to group g issues before cycle c + t_same_grp_i.
- R4: After any read issues in cycle c, no further read issues before cycle c + t_diff_bank_i.
- R5: A read accepted at a clock edge can issue in the cycle that follows. The scheduler never leaves a cycle idle while some queued read has both of its timers expired.
- R6: Among eligible reads, the oldest one whose group differs from the last issued group is chosen, even when an older read to the last group is also eligible.
- R7: If no eligible read differs from the last issued group, the oldest eligible read is chosen. Reads to the same group therefore leave in arrival order.
- R8: The queue holds 8 reads. With 8 reads queued, req_ready_o is low. A read offered while ready is low is dropped and never issues.
- R9: Reset empties the queue and clears every timer. After reset, req_ready_o is high and no read issues. The first read accepted afterwards issues in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A read request is offered |
| req_group_i | input | 2 | Bank group of the offered read |
| req_bank_i | input | 2 | Bank within the group of the offered read |
| req_ready_o | output | 1 | Queue has space; the offer is taken at this edge |
| t_same_grp_i | input | 6 | Minimum clocks between reads to one group |
| t_diff_bank_i | input | 6 | Minimum clocks between reads to different banks |
| cmd_valid_o | output | 1 | A read command is issued this cycle |
| cmd_group_o | output | 2 | Bank group of the issued read |
| cmd_bank_o | output | 2 | Bank of the issued read |

## Verification
The assertions check several properties on every cycle. No two adjacent reads go to the same group. Reads are never back to back while the different-bank spacing is at least 2. A read issues only when both of its timers are zero and the queue is not empty. The queue count moves exactly by the number of accepted and issued reads. The bench scenarios cover what a single-cycle property cannot see. They confirm that the group spacing holds across many cycles and that the oldest other-group read overtakes older same-group reads. They also show the fallback to arrival order, that a refused read is really dropped, and that a reset in the middle of traffic leaves no trace.

// File: rtl/bg_sched_pkg.sv
package bg_sched_pkg;
  localparam int GRP_W  = 2;
  localparam int BANK_W = 2;
  localparam int NUM_GRP = 1 << GRP_W;
  localparam int BANKS_PER_GRP = 1 << BANK_W;
  localparam int NUM_BANK = NUM_GRP * BANKS_PER_GRP;

  typedef struct packed {
    logic [GRP_W-1:0]  grp;
    logic [BANK_W-1:0] bank;
  } rd_req_t;
endpackage

// File: rtl/bg_rd_queue.sv
module bg_rd_queue
  import bg_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  rd_req_t                push_req_i,
  input  logic                   pop_i,
  input  logic [IDX_W-1:0]       pop_idx_i,
  output rd_req_t [DEPTH-1:0]    entries_o,
  output logic    [DEPTH-1:0]    valid_o,
  output logic                   ready_o,
  output logic    [CNT_W-1:0]    count_o
);
  rd_req_t [DEPTH-1:0] q, q_nxt;
  logic [CNT_W-1:0] cnt, cnt_pop;
  logic take;

  assign ready_o = (cnt != CNT_W'(DEPTH));
  assign take    = push_i && ready_o;
  assign cnt_pop = cnt - CNT_W'(pop_i);

  // index 0 holds the oldest entry; popping compacts the tail down
  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (pop_i && i >= int'(pop_idx_i)) q_nxt[i] = q[i+1];
      else                               q_nxt[i] = q[i];
    end
    q_nxt[DEPTH-1] = q[DEPTH-1];
    if (take) q_nxt[cnt_pop[IDX_W-1:0]] = push_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q   <= '0;
      cnt <= '0;
    end else begin
      q   <= q_nxt;
      cnt <= cnt_pop + CNT_W'(take);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_vld
    assign valid_o[i] = (CNT_W'(i) < cnt);
  end

  assign entries_o = q;
  assign count_o   = cnt;

  assert_count_track_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == $past(cnt) + CNT_W'($past(take)) - CNT_W'($past(pop_i)));
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !ready_o) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/bg_sched_timers.sv
module bg_sched_timers
  import bg_sched_pkg::*;
#(
  parameter int TMR_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [GRP_W-1:0]     issue_grp_i,
  input  logic [TMR_W-1:0]     t_same_grp_i,
  input  logic [TMR_W-1:0]     t_diff_bank_i,
  output logic [NUM_GRP-1:0]   grp_free_o,
  output logic [NUM_BANK-1:0]  bank_free_o
);
  logic [TMR_W-1:0] sg_load, db_load;

  // an interval of N clocks means N-1 blocked cycles after the issue
  assign sg_load = (t_same_grp_i  == '0) ? '0 : t_same_grp_i  - 1'b1;
  assign db_load = (t_diff_bank_i == '0) ? '0 : t_diff_bank_i - 1'b1;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [TMR_W-1:0] tmr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  tmr <= '0;
      else if (issue_i && issue_grp_i == GRP_W'(g)) tmr <= sg_load;
      else if (tmr != '0)                           tmr <= tmr - 1'b1;
    end
    assign grp_free_o[g] = (tmr == '0);
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [TMR_W-1:0] tmr, dec;
    assign dec = (tmr != '0) ? tmr - 1'b1 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tmr <= '0;
      else if (issue_i) tmr <= (dec > db_load) ? dec : db_load;
      else              tmr <= dec;
    end
    assign bank_free_o[b] = (tmr == '0);
  end
endmodule

// File: rtl/bg_sched_pick.sv
module bg_sched_pick
  import bg_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  rd_req_t [DEPTH-1:0]   entries_i,
  input  logic    [DEPTH-1:0]   valid_i,
  input  logic [NUM_GRP-1:0]    grp_free_i,
  input  logic [NUM_BANK-1:0]   bank_free_i,
  input  logic [GRP_W-1:0]      last_grp_i,
  input  logic                  last_vld_i,
  output logic                  pick_vld_o,
  output logic [IDX_W-1:0]      pick_idx_o
);
  logic [DEPTH-1:0] elig;
  logic pref_hit, fb_hit;
  logic [IDX_W-1:0] pref_idx, fb_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    assign elig[i] = valid_i[i] && grp_free_i[entries_i[i].grp]
                   && bank_free_i[{entries_i[i].grp, entries_i[i].bank}];
  end

  // scan youngest to oldest so the oldest match is kept
  always_comb begin
    pref_hit = 1'b0;
    fb_hit   = 1'b0;
    pref_idx = '0;
    fb_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        fb_hit = 1'b1;
        fb_idx = IDX_W'(i);
        if (!last_vld_i || entries_i[i].grp != last_grp_i) begin
          pref_hit = 1'b1;
          pref_idx = IDX_W'(i);
        end
      end
    end
  end

  assign pick_vld_o = fb_hit;
  assign pick_idx_o = pref_hit ? pref_idx : fb_idx;
endmodule

// File: rtl/bg_read_sched.sv
module bg_read_sched
  import bg_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TMR_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [GRP_W-1:0]   req_group_i,
  input  logic [BANK_W-1:0]  req_bank_i,
  output logic               req_ready_o,
  input  logic [TMR_W-1:0]   t_same_grp_i,
  input  logic [TMR_W-1:0]   t_diff_bank_i,
  output logic               cmd_valid_o,
  output logic [GRP_W-1:0]   cmd_group_o,
  output logic [BANK_W-1:0]  cmd_bank_o
);
  rd_req_t [DEPTH-1:0] entries;
  logic [DEPTH-1:0]    valid;
  logic [CNT_W-1:0]    q_count;
  logic [NUM_GRP-1:0]  grp_free;
  logic [NUM_BANK-1:0] bank_free;
  logic                pick_vld;
  logic [IDX_W-1:0]    pick_idx;
  logic [GRP_W-1:0]    last_grp;
  logic                last_vld;
  rd_req_t             push_req;

  assign push_req = '{grp: req_group_i, bank: req_bank_i};

  bg_rd_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i(req_valid_i), .push_req_i(push_req),
    .pop_i(pick_vld), .pop_idx_i(pick_idx),
    .entries_o(entries), .valid_o(valid),
    .ready_o(req_ready_o), .count_o(q_count)
  );

  bg_sched_timers #(.TMR_W(TMR_W)) u_timers (
    .clk_i, .rst_ni,
    .issue_i(pick_vld), .issue_grp_i(cmd_group_o),
    .t_same_grp_i, .t_diff_bank_i,
    .grp_free_o(grp_free), .bank_free_o(bank_free)
  );

  bg_sched_pick #(.DEPTH(DEPTH)) u_pick (
    .entries_i(entries), .valid_i(valid),
    .grp_free_i(grp_free), .bank_free_i(bank_free),
    .last_grp_i(last_grp), .last_vld_i(last_vld),
    .pick_vld_o(pick_vld), .pick_idx_o(pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_grp <= '0;
      last_vld <= 1'b0;
    end else if (pick_vld) begin
      last_grp <= cmd_group_o;
      last_vld <= 1'b1;
    end
  end

  assign cmd_valid_o = pick_vld;
  assign cmd_group_o = entries[pick_idx].grp;
  assign cmd_bank_o  = entries[pick_idx].bank;

  assert_issue_from_queue_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (q_count != '0));
  assert_grp_alternate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !(cmd_valid_o && cmd_group_o == $past(cmd_group_o)));
  assert_bank_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && t_diff_bank_i >= TMR_W'(2)) |=> !cmd_valid_o);
  assert_timers_expired_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (grp_free[cmd_group_o] && bank_free[{cmd_group_o, cmd_bank_o}]));
endmodule

// File: tb/bg_read_sched_test.sv
module bg_read_sched_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_group = '0, req_bank = '0;
  logic req_ready;
  logic [5:0] t_sg = 6'd2, t_db = 6'd2;
  logic cmd_valid;
  logic [1:0] cmd_group, cmd_bank;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bg_read_sched uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_group_i(req_group), .req_bank_i(req_bank),
    .req_ready_o(req_ready),
    .t_same_grp_i(t_sg), .t_diff_bank_i(t_db),
    .cmd_valid_o(cmd_valid), .cmd_group_o(cmd_group), .cmd_bank_o(cmd_bank)
  );

  // request / expected nibble = {group, bank}
  typedef struct packed {
    logic [5:0]       sg;
    logic [5:0]       db;
    logic [0:3][3:0]  req;
    logic [0:3][3:0]  exp_gb;
    logic [0:3][4:0]  exp_cyc;
  } scen_t;

  localparam scen_t SCEN [4] = '{
    '{6'd4, 6'd2, {4'h0, 4'h1, 4'h4, 4'hB}, {4'h0, 4'h4, 4'h1, 4'hB}, {5'd0, 5'd2, 5'd4, 5'd6}},
    '{6'd2, 6'd2, {4'h0, 4'h5, 4'hA, 4'hF}, {4'h0, 4'h5, 4'hA, 4'hF}, {5'd0, 5'd2, 5'd4, 5'd6}},
    '{6'd6, 6'd3, {4'h8, 4'h9, 4'hA, 4'hB}, {4'h8, 4'h9, 4'hA, 4'hB}, {5'd0, 5'd6, 5'd12, 5'd18}},
    '{6'd3, 6'd2, {4'h4, 4'h5, 4'h6, 4'hC}, {4'h4, 4'hC, 4'h5, 4'h6}, {5'd0, 5'd3, 5'd5, 5'd8}}
  };
  string scen_tag [4] = '{"R6 R5", "R4 R1", "R3 R2", "R7 R5"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [3:0] gb);
    req_valid = v;
    req_group = gb[3:2];
    req_bank  = gb[1:0];
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    logic [0:3][3:0] got_gb;
    int got_cyc [4];

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9 ready in reset", int'(req_ready), 1);
    check(cmd_valid == 1'b0, "R9 idle in reset", int'(cmd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && cmd_valid == 1'b0, "R9 after reset", int'({req_ready, cmd_valid}), 2);

    // table-driven scenarios
    for (int s = 0; s < 4; s++) begin
      t_sg = SCEN[s].sg;
      t_db = SCEN[s].db;
      n = 0;
      got_gb = '0;
      drive(1'b1, SCEN[s].req[0]);
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (cmd_valid) begin
          if (n < 4) begin
            got_gb[n] = {cmd_group, cmd_bank};
            got_cyc[n] = k;
          end
          n++;
        end
        if (k + 1 < 4) drive(1'b1, SCEN[s].req[k+1]);
        else           drive(1'b0, 4'h0);
      end
      check(n == 4, $sformatf("%s scen%0d issue count", scen_tag[s], s), n, 4);
      for (int j = 0; j < 4; j++) begin
        check(got_gb[j] == SCEN[s].exp_gb[j],
              $sformatf("%s scen%0d read%0d group/bank", scen_tag[s], s, j),
              int'(got_gb[j]), int'(SCEN[s].exp_gb[j]));
        check(got_cyc[j] == int'(SCEN[s].exp_cyc[j]),
              $sformatf("%s scen%0d read%0d cycle", scen_tag[s], s, j),
              got_cyc[j], int'(SCEN[s].exp_cyc[j]));
      end
    end

    // full queue: long spacing holds everything back
    t_sg = 6'd40;
    t_db = 6'd40;
    drive(1'b1, 4'h0);
    @(negedge clk);
    check(cmd_valid == 1'b1, "R5 first read issues", int'(cmd_valid), 1);
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, (k % 2 == 0) ? 4'h5 : 4'h9);
      @(negedge clk);
    end
    check(req_ready == 1'b0, "R8 ready low when full", int'(req_ready), 0);
    drive(1'b1, 4'hF);
    repeat (2) @(negedge clk);
    drive(1'b0, 4'h0);
    begin
      int cnt;
      int bad_gb;
      cnt = 0;
      bad_gb = 0;
      for (int k = 0; k < 400; k++) begin
        if (cmd_valid) begin
          cnt++;
          if ({cmd_group, cmd_bank} == 4'hF) bad_gb++;
        end
        @(negedge clk);
      end
      check(cnt == 8, "R8 queued reads drained", cnt, 8);
      check(bad_gb == 0, "R8 refused read dropped", bad_gb, 0);
      check(req_ready == 1'b1, "R8 ready after drain", int'(req_ready), 1);
    end

    // reset in the middle of traffic
    drive(1'b1, 4'h2);
    @(negedge clk);
    drive(1'b1, 4'h6);
    @(negedge clk);
    drive(1'b0, 4'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after mid reset", int'(req_ready), 1);
    check(cmd_valid == 1'b0, "R9 queue emptied", int'(cmd_valid), 0);
    drive(1'b1, 4'h6);
    @(negedge clk);
    drive(1'b0, 4'h0);
    check(cmd_valid == 1'b1 && {cmd_group, cmd_bank} == 4'h6, "R9 timers cleared",
          int'({cmd_valid, cmd_group, cmd_bank}), 'h16);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (cmd_valid) extra++;
      end
      check(extra == 0, "R9 stale read gone", extra, 0);
    end

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule